// File: doc/BRIEF.md
# Vector Source Operand Expand Unit

This unit prepares a single 128-bit source operand on its way into a vector arithmetic unit. It can leave the two 64-bit halves alone, copy one half over the other, exchange them, or take one half and stretch every element in it to twice its width, optionally exchanging the halves of the stretched result afterwards. The stretched value is then rearranged by a four-way swizzle of 32-bit components. For a floating-point operand, the unit finally clears and/or flips the sign bit of each lane.

The unit is purely combinational and holds no state. Every input is a plain level, and the result follows its inputs within the same cycle. There is no flow control at its edge, because the surrounding pipeline register owns timing and back-pressure. A lane-width code gives the source element size used for stretching. The same code, advanced by one step when stretching, gives the lane size on which the sign operations act.

Top module: `vector_operand_expand`

## Requirements
- R1: With expand code 0, the identity swizzle 8'hE4 and the integer type, the result equals the operand. With all inputs zero, the result is zero.
- R2: Expand code 1 places the low 64 bits in both halves. Expand code 2 places the high 64 bits in both halves.
- R3: Expand code 3 exchanges the halves, so result[127:64] = operand[63:0] and result[63:0] = operand[127:64].
- R4: Codes 4 and 5 widen the low half (code 4) or the high half (code 5). The source element width is 8 << lane code, with lane code 0..3. Element j of that half becomes the result element j, of twice that width, counted from bit 0.
- R5: For an integer operand that is widened, the modifier selects how each element e of width S is widened. Modifier 0 sign-extends e. Modifier 1 zero-extends e. Modifier 2 gives {e,e}. Modifier 3 gives {e, S zero bits}.
- R6: Codes 6 and 7 widen the low half and the high half respectively, as codes 4 and 5 do, and then exchange the 64-bit halves of the widened value.
- R7: For a float operand, widening always sign-extends the raw element bits, whatever the modifier value.
- R8: For a float operand, modifier bit 0 clears the top bit of every lane. Modifier bit 1 then inverts that bit. This applies under every expand code. The lane width is 8 << lane code without widening and 16 << lane code with widening.
- R9: The swizzle is applied after expansion and before the sign operations. Output 32-bit component i (bits 32i+31..32i) takes expanded component swizzle[2i+1:2i].
- R10: For an integer operand under codes 0..3, the modifier has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 128 | Source operand |
| xmode_i | input | 3 | Expand code 0..7 |
| modf_i | input | 2 | Modifier: integer widening rule, or float abs (bit 0) and negate (bit 1) |
| swz_i | input | 8 | Four 2-bit component selectors, component 0 in bits 1:0 |
| lanew_i | input | 2 | Lane-width code: element width 8 << code |
| is_float_i | input | 1 | 1 selects float interpretation |
| result_o | output | 128 | Conditioned operand |

## Verification
Three stages can act on the same operand in one evaluation: half handling or widening, the swizzle, and the float sign operations. Swap-after-widen codes are combined with non-identity swizzles, and float modifiers with widening, so that any error in the order of these stages shows up as a wrong bit position. The bench sweeps every expand code, modifier, lane code and type against several operand patterns and three swizzles. A bench model, written bit by bit, predicts each result.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  typedef enum logic [2:0] {
    XM_PASS      = 3'd0,
    XM_DUP_LO    = 3'd1,
    XM_DUP_HI    = 3'd2,
    XM_SWAP      = 3'd3,
    XM_WID_LO    = 3'd4,
    XM_WID_HI    = 3'd5,
    XM_WID_LO_SW = 3'd6,
    XM_WID_HI_SW = 3'd7
  } xmode_e;

  typedef enum logic [1:0] {
    IM_SEXT = 2'd0,
    IM_ZEXT = 2'd1,
    IM_REPL = 2'd2,
    IM_SHL  = 2'd3
  } imod_e;

  function automatic logic xm_widens(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic xm_swaps(input logic [2:0] m);
    return (m == XM_SWAP) || (m[2] && m[1]);
  endfunction
endpackage

// File: rtl/vexp_widen.sv
module vexp_widen
  import vexp_pkg::*;
#(
  parameter int unsigned HALF_W   = 64,
  parameter int unsigned MIN_ELEM = 8,
  parameter int unsigned NWCODE   = 4,
  localparam int unsigned WC_W    = $clog2(NWCODE)
) (
  input  logic [HALF_W-1:0]   half_i,
  input  logic [WC_W-1:0]     wcode_i,
  input  logic [1:0]          imod_i,
  input  logic                is_float_i,
  output logic [2*HALF_W-1:0] wide_o
);
  logic [1:0] rule;
  logic [2*HALF_W-1:0] cand [NWCODE];

  // Float widening is always a raw sign extension.
  assign rule = is_float_i ? IM_SEXT : imod_i;

  for (genvar k = 0; k < NWCODE; k++) begin : g_code
    localparam int unsigned S = MIN_ELEM << k;
    localparam int unsigned N = HALF_W / S;
    logic [2*HALF_W-1:0] v;
    for (genvar j = 0; j < N; j++) begin : g_elem
      logic [S-1:0] e;
      assign e = half_i[j*S +: S];
      assign v[j*2*S +: 2*S] =
        (rule == IM_SEXT) ? {{S{e[S-1]}}, e} :
        (rule == IM_ZEXT) ? {{S{1'b0}}, e}   :
        (rule == IM_REPL) ? {e, e}           :
                            {e, {S{1'b0}}};
    end
    assign cand[k] = v;
  end

  assign wide_o = cand[wcode_i];
endmodule

// File: rtl/vexp_halves.sv
module vexp_halves
  import vexp_pkg::*;
#(
  parameter int unsigned OPND_W   = 128,
  parameter int unsigned MIN_ELEM = 8,
  parameter int unsigned NWCODE   = 4,
  localparam int unsigned HALF_W  = OPND_W / 2,
  localparam int unsigned WC_W    = $clog2(NWCODE)
) (
  input  logic [OPND_W-1:0] opnd_i,
  input  logic [2:0]        xmode_i,
  input  logic [WC_W-1:0]   wcode_i,
  input  logic [1:0]        imod_i,
  input  logic              is_float_i,
  output logic [OPND_W-1:0] staged_o
);
  logic [HALF_W-1:0] lo, hi, pick;
  logic [OPND_W-1:0] wide;

  assign lo   = opnd_i[HALF_W-1:0];
  assign hi   = opnd_i[OPND_W-1:HALF_W];
  // Odd widening codes take the upper half.
  assign pick = xmode_i[0] ? hi : lo;

  vexp_widen #(
    .HALF_W(HALF_W), .MIN_ELEM(MIN_ELEM), .NWCODE(NWCODE)
  ) u_widen (
    .half_i(pick), .wcode_i(wcode_i), .imod_i(imod_i),
    .is_float_i(is_float_i), .wide_o(wide)
  );

  always_comb begin
    unique case (xmode_i)
      XM_PASS:   staged_o = opnd_i;
      XM_DUP_LO: staged_o = {lo, lo};
      XM_DUP_HI: staged_o = {hi, hi};
      XM_SWAP:   staged_o = {lo, hi};
      XM_WID_LO, XM_WID_HI:
                 staged_o = wide;
      default:   staged_o = {wide[HALF_W-1:0], wide[OPND_W-1:HALF_W]};
    endcase
  end
endmodule

// File: rtl/vexp_swizzle.sv
module vexp_swizzle #(
  parameter int unsigned OPND_W  = 128,
  parameter int unsigned COMP_W  = 32,
  localparam int unsigned NCOMP  = OPND_W / COMP_W,
  localparam int unsigned SEL_W  = $clog2(NCOMP)
) (
  input  logic [OPND_W-1:0]      in_i,
  input  logic [NCOMP*SEL_W-1:0] swz_i,
  output logic [OPND_W-1:0]      out_o
);
  logic [COMP_W-1:0] comp [NCOMP];

  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    assign comp[i] = in_i[i*COMP_W +: COMP_W];
    assign out_o[i*COMP_W +: COMP_W] = comp[swz_i[i*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/vexp_fmod.sv
module vexp_fmod #(
  parameter int unsigned OPND_W   = 128,
  parameter int unsigned MIN_ELEM = 8,
  parameter int unsigned NLW      = 5,
  localparam int unsigned LC_W    = $clog2(NLW)
) (
  input  logic [OPND_W-1:0] in_i,
  input  logic [LC_W-1:0]   lcode_i,
  input  logic              abs_i,
  input  logic              neg_i,
  output logic [OPND_W-1:0] out_o
);
  logic [OPND_W-1:0] msk [NLW];
  logic [OPND_W-1:0] sign_m;

  for (genvar c = 0; c < NLW; c++) begin : g_lane
    localparam int unsigned L = MIN_ELEM << c;
    for (genvar b = 0; b < OPND_W; b++) begin : g_bit
      assign msk[c][b] = ((b % L) == (L - 1)) ? 1'b1 : 1'b0;
    end
  end

  assign sign_m = (32'(lcode_i) < NLW) ? msk[lcode_i] : '0;
  assign out_o  = (in_i & ~(abs_i ? sign_m : '0)) ^ (neg_i ? sign_m : '0);
endmodule

// File: rtl/vector_operand_expand.sv
module vector_operand_expand
  import vexp_pkg::*;
#(
  parameter int unsigned OPND_W   = 128,
  parameter int unsigned COMP_W   = 32,
  parameter int unsigned MIN_ELEM = 8,
  parameter int unsigned NWCODE   = 4,
  localparam int unsigned NCOMP   = OPND_W / COMP_W,
  localparam int unsigned SWZ_W   = NCOMP * $clog2(NCOMP),
  localparam int unsigned WC_W    = $clog2(NWCODE),
  localparam int unsigned NLW     = NWCODE + 1,
  localparam int unsigned LC_W    = $clog2(NLW)
) (
  input  logic [OPND_W-1:0] opnd_i,
  input  logic [2:0]        xmode_i,
  input  logic [1:0]        modf_i,
  input  logic [SWZ_W-1:0]  swz_i,
  input  logic [WC_W-1:0]   lanew_i,
  input  logic              is_float_i,
  output logic [OPND_W-1:0] result_o
);
  logic [OPND_W-1:0] staged, swizzled;
  logic [LC_W-1:0]   lcode;

  vexp_halves #(
    .OPND_W(OPND_W), .MIN_ELEM(MIN_ELEM), .NWCODE(NWCODE)
  ) u_halves (
    .opnd_i(opnd_i), .xmode_i(xmode_i), .wcode_i(lanew_i),
    .imod_i(modf_i), .is_float_i(is_float_i), .staged_o(staged)
  );

  vexp_swizzle #(.OPND_W(OPND_W), .COMP_W(COMP_W)) u_swz (
    .in_i(staged), .swz_i(swz_i), .out_o(swizzled)
  );

  // Lane size for sign operations grows one step when widening.
  assign lcode = LC_W'(lanew_i) + LC_W'(xm_widens(xmode_i));

  vexp_fmod #(.OPND_W(OPND_W), .MIN_ELEM(MIN_ELEM), .NLW(NLW)) u_fmod (
    .in_i(swizzled), .lcode_i(lcode),
    .abs_i(is_float_i & modf_i[0]), .neg_i(is_float_i & modf_i[1]),
    .out_o(result_o)
  );
endmodule

// File: rtl/vexp_chk.sv
module vexp_chk (
  input logic [127:0] opnd_i,
  input logic [2:0]   xmode_i,
  input logic [1:0]   modf_i,
  input logic [7:0]   swz_i,
  input logic [1:0]   lanew_i,
  input logic         is_float_i,
  input logic [127:0] result_o
);
  logic known, ident;
  assign known = !$isunknown({opnd_i, xmode_i, modf_i, swz_i, lanew_i, is_float_i, result_o});
  assign ident = (swz_i == 8'hE4);

  always_comb begin
    if (known) begin
      p_pass_r1: assert (!(!is_float_i && ident && xmode_i == 3'd0) || result_o == opnd_i)
        else $error("R1 passthrough mismatch");
      p_dup_r2: assert (!(!is_float_i && ident && xmode_i == 3'd1) || result_o[127:64] == result_o[63:0])
        else $error("R2 halves differ after low copy");
      p_swap_r3: assert (!(!is_float_i && ident && xmode_i == 3'd3) ||
                         result_o == {opnd_i[63:0], opnd_i[127:64]})
        else $error("R3 swap mismatch");
      p_zext_r5: assert (!(!is_float_i && ident && xmode_i == 3'd4 && modf_i == 2'd1 && lanew_i == 2'd3) ||
                         result_o[127:64] == 64'd0)
        else $error("R5 zero extension leaves upper bits set");
      p_abs_r8: assert (!(is_float_i && ident && xmode_i == 3'd0 && modf_i == 2'd1 && lanew_i == 2'd2) ||
                        {result_o[127], result_o[95], result_o[63], result_o[31]} == 4'b0)
        else $error("R8 abs left a sign bit set");
      p_bcast_r9: assert (!(!is_float_i && swz_i == 8'h00) ||
                          (result_o[127:96] == result_o[31:0] && result_o[95:64] == result_o[31:0] &&
                           result_o[63:32] == result_o[31:0]))
        else $error("R9 broadcast swizzle components differ");
    end
  end
endmodule

bind vector_operand_expand vexp_chk u_chk (.*);

// File: tb/sim_vector_operand_expand.sv
module sim_vector_operand_expand;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [127:0] opnd;
  logic [2:0]   xmode;
  logic [1:0]   modf;
  logic [7:0]   swz;
  logic [1:0]   lanew;
  logic         isf;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  vector_operand_expand u0 (
    .opnd_i(opnd), .xmode_i(xmode), .modf_i(modf), .swz_i(swz),
    .lanew_i(lanew), .is_float_i(isf), .result_o(result)
  );

  function automatic logic [127:0] model(input logic [127:0] op, input int xm, input int md,
                                         input logic [7:0] sw, input int lw, input bit fl);
    logic [127:0] t, z;
    logic [63:0] h;
    int s, l, rule;
    bit wid;
    wid = (xm >= 4);
    t = '0;
    case (xm)
      0: t = op;
      1: t = {op[63:0], op[63:0]};
      2: t = {op[127:64], op[127:64]};
      3: t = {op[63:0], op[127:64]};
      default: begin
        h = (xm == 4 || xm == 6) ? op[63:0] : op[127:64];
        s = 8 << lw;
        rule = fl ? 0 : md;
        for (int j = 0; j < 64 / s; j++) begin
          for (int b = 0; b < 2 * s; b++) begin
            case (rule)
              0: t[j*2*s+b] = h[j*s + ((b < s) ? b : s - 1)];
              1: t[j*2*s+b] = (b < s) ? h[j*s+b] : 1'b0;
              2: t[j*2*s+b] = h[j*s + (b % s)];
              default: t[j*2*s+b] = (b < s) ? 1'b0 : h[j*s+b-s];
            endcase
          end
        end
        if (xm >= 6) t = {t[63:0], t[127:64]};
      end
    endcase
    for (int i = 0; i < 4; i++) z[i*32 +: 32] = t[int'(sw[2*i +: 2])*32 +: 32];
    if (fl) begin
      l = 8 << (wid ? lw + 1 : lw);
      for (int p = l - 1; p < 128; p += l) begin
        if (md[0]) z[p] = 1'b0;
        if (md[1]) z[p] = ~z[p];
      end
    end
    return z;
  endfunction

  task automatic run(input logic [127:0] op, input int xm, input int md, input logic [7:0] sw,
                     input int lw, input bit fl, input string req);
    logic [127:0] exp_v;
    @(negedge clk);
    opnd = op; xmode = 3'(xm); modf = 2'(md); swz = sw; lanew = 2'(lw); isf = fl;
    exp_v = model(op, xm, md, sw, lw, fl);
    #5;
    checks++;
    if (result !== exp_v) begin
      errors++;
      $display("FAIL %s xm=%0d md=%0d lw=%0d fl=%0d sw=%h actual=%h expected=%h",
               req, xm, md, lw, fl, sw, result, exp_v);
    end
  endtask

  function automatic string tag(input int xm, input int md, input logic [7:0] sw, input bit fl);
    if (sw != 8'hE4) return "R9";
    if (fl) return (md != 0) ? "R8" : ((xm >= 4) ? "R7" : "R1");
    case (xm)
      0: return (md != 0) ? "R10" : "R1";
      1, 2: return "R2";
      3: return "R3";
      4, 5: return (md != 0) ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  initial begin
    logic [127:0] pats [4];
    logic [7:0] swzs [3];
    pats[0] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    pats[1] = 128'h8000_7FFF_80FF_7F00_F0F0_0F0F_8181_7E7E;
    pats[2] = '1;
    pats[3] = 128'hC3A5_5A3C_9966_1248_8421_EDB7_0001_8000;
    swzs[0] = 8'hE4; swzs[1] = 8'h1B; swzs[2] = 8'h00;
    opnd = '0; xmode = '0; modf = '0; swz = 8'hE4; lanew = '0; isf = 1'b0;
    // R1: all-zero inputs give a zero result
    run('0, 0, 0, 8'hE4, 0, 1'b0, "R1");
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 3; s++)
        for (int xm = 0; xm < 8; xm++)
          for (int md = 0; md < 4; md++)
            for (int lw = 0; lw < 4; lw++)
              for (int fl = 0; fl < 2; fl++)
                run(pats[p], xm, md, swzs[s], lw, fl[0], tag(xm, md, swzs[s], fl[0]));
    // R9 with a non-trivial selector, float negate after swizzle, widen-then-swap
    run(pats[3], 7, 2, 8'h4E, 1, 1'b1, "R9");
    run(pats[0], 6, 3, 8'h4E, 2, 1'b0, "R6");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule